// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Channel

This block moves outgoing packets from memory to a switch port without processor help. Software builds a circular list of descriptors in memory. Each descriptor is four 32-bit words and names one packet buffer. The engine walks that list and fetches each buffer through a simple word-wide memory port. It sends the bytes out on a byte stream that has valid/ready flow control and a last marker.

Ownership of a descriptor rests on two flags. A hold flag in the parameter word stops the walk, and a completion flag in the status word is set by the engine once the buffer has been sent. Software sets up the channel with three commands:
- an initialise command, which loads the first descriptor address and the poll interval;
- a release command, which makes a parked engine look at its descriptor again at once;
- an off command, which stops the channel at the next descriptor boundary.

While it is parked, the engine also re-reads the descriptor on its own each time the poll interval runs out. The usual poll interval is 7 cycles.

Top module: `txr_dma_top`

## Requirements
- R1: After reset, no memory request is made and the stream is idle. A release or off command given before any initialise command causes no memory activity.
- R2: On initialise, the engine reads the descriptor at the given base address with the low 4 address bits cleared. It reads the words in this order: byte offset 0 (parameters), offset 12 (status), offset 8 (buffer pointer), offset 4 (next pointer).
- R3: The engine parks on a descriptor whose parameter bit 31 (hold) is 1 or whose status bit 31 (complete) is 1. It fetches no buffer data and emits no byte for that descriptor.
- R4: While parked, the engine re-reads the descriptor once the captured poll interval has elapsed. It makes no descriptor read before then, and it picks up a released descriptor without any command.
- R5: A release command (code 2) given while parked makes the engine re-read the parameter word within a few cycles.
- R6: The engine emits exactly the number of bytes given in parameter bits 21:0. The bytes come from the buffer pointer onwards in little-endian lane order, for any byte alignment of the pointer.
- R7: The last output is high on the final byte of a descriptor whose parameter bit 30 (end of packet) is 1, and on no other byte.
- R8: While the ready input is low, the offered byte and last marker hold steady, and no byte is lost or repeated.
- R9: After the final byte is accepted, the engine writes the status word back with bit 31 set and all other bits unchanged.
- R10: The engine follows the next pointer with its low 4 bits ignored, so the last entry pointing to the first closes the ring.
- R11: A descriptor with a zero byte count is completed, with its status bit 31 set, and emits no byte.
- R12: An off command (code 3) stops the channel once it is parked or has finished its current descriptor. A later initialise command (code 1) restarts the walk from the new base address.
- R13: Every memory request uses a word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 1 initialise, 2 release hold, 3 off |
| base_addr | input | AW | First descriptor address, taken on initialise |
| poll_ivl | input | PW | Poll interval in cycles, taken on initialise |
| mem_req | output | 1 | Memory access request, accepted in the same cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Byte stream valid |
| out_data | output | 8 | Byte stream data |
| out_last | output | 1 | Final byte of an end-of-packet descriptor |
| out_ready | input | 1 | Byte stream ready |

## Verification
The hardest state to reach from the ports is a parked engine whose descriptor software changes while it waits. The poll window and the release command then race each other. The stimulus parks the engine with a long poll interval and counts parameter-word reads while the window is still open. It then clears the hold flag and gives a release command, and checks that a read follows at once. In another case it releases a zero-length descriptor with no command at all, so that only the poll timer can find it. The off command is tested the same way: the channel is parked, a descriptor is handed over, and a release command is shown to draw no memory traffic.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 22;
  localparam int HOLD_BIT  = 31;
  localparam int EOP_BIT   = 30;
  localparam int DONE_BIT  = 31;
  localparam int OFF_PARAM = 0;
  localparam int OFF_NEXT  = 4;
  localparam int OFF_BUF   = 8;
  localparam int OFF_STAT  = 12;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_INIT    = 2'd1,
    CMD_RELEASE = 2'd2,
    CMD_OFF     = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    W_IDLE, W_RD_PAR, W_WT_PAR, W_RD_STS, W_WT_STS, W_RD_BUF, W_WT_BUF,
    W_RD_NXT, W_WT_NXT, W_RD_DAT, W_WT_DAT, W_EMIT, W_WB, W_PARK
  } wstate_e;
endpackage

// File: rtl/txr_cmd.sv
module txr_cmd import txr_pkg::*; #(
  parameter int AW = 32,
  parameter int PW = 8,
  parameter int POLL_RESET = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  input  logic [AW-1:0] base_addr,
  input  logic [PW-1:0] poll_ivl,
  input  logic          walker_idle,
  output logic          run_q,
  output logic          start_q,
  output logic          kick_q,
  output logic [AW-1:0] base_q,
  output logic [PW-1:0] poll_q
);
  cmd_e code;
  assign code = cmd_e'(cmd_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      kick_q  <= 1'b0;
      base_q  <= '0;
      poll_q  <= PW'(POLL_RESET);
    end else begin
      start_q <= 1'b0;
      kick_q  <= 1'b0;
      if (cmd_valid) begin
        case (code)
          CMD_INIT: begin
            if (!run_q && walker_idle) begin
              run_q   <= 1'b1;
              start_q <= 1'b1;
              base_q  <= base_addr;
              poll_q  <= poll_ivl;
            end
          end
          CMD_RELEASE: if (run_q) kick_q <= 1'b1;
          CMD_OFF:     run_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_q |-> walker_idle && run_q); // R12
endmodule

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] ivl,
  output logic          expired
);
  logic [PW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= ivl;
      armed_q <= 1'b1;
    end else if (armed_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = armed_q && (cnt_q == '0);
endmodule

// File: rtl/txr_byte_out.sv
module txr_byte_out #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic [1:0]    load_lane,
  input  logic [2:0]    load_cnt,
  input  logic          load_last,
  output logic          idle,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready
);
  logic [DW-1:0] word_q;
  logic [1:0]    lane_q;
  logic [2:0]    cnt_q;
  logic          last_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      lane_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (load && !busy_q) begin
      word_q <= load_word;
      lane_q <= load_lane;
      cnt_q  <= load_cnt;
      last_q <= load_last;
      busy_q <= (load_cnt != 3'd0);
    end else if (busy_q && out_ready) begin
      if (cnt_q == 3'd1) begin
        busy_q <= 1'b0;
      end else begin
        lane_q <= lane_q + 2'd1;
        cnt_q  <= cnt_q - 3'd1;
      end
    end
  end

  assign idle      = !busy_q;
  assign out_valid = busy_q;
  assign out_data  = word_q[{lane_q, 3'b000} +: 8];
  assign out_last  = busy_q && last_q && (cnt_q == 3'd1);

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R8
endmodule

// File: rtl/txr_walker.sv
module txr_walker import txr_pkg::*; #(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     base,
  input  logic              run,
  input  logic              kick,
  input  logic              poll_exp,
  output logic              poll_start,
  output logic              idle,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ser_load,
  output logic [WORD_W-1:0] ser_word,
  output logic [1:0]        ser_lane,
  output logic [2:0]        ser_cnt,
  output logic              ser_last,
  input  logic              ser_idle
);
  localparam logic [AW-1:0] DESC_MASK = ~AW'(15);

  wstate_e           st_q;
  logic [AW-1:0]     cur_q, nxt_q, ba_q;
  logic [CNT_W-1:0]  rem_q;
  logic              hold_q, eop_q;
  logic [WORD_W-1:0] sts_q;
  logic [2:0]        avail, take;
  logic [CNT_W-1:0]  take_w;

  always_comb begin
    avail  = 3'd4 - {1'b0, ba_q[1:0]};
    take   = (rem_q < CNT_W'(avail)) ? rem_q[2:0] : avail;
    take_w = CNT_W'(take);
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur_q;
    case (st_q)
      W_RD_PAR: begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFF_PARAM); end
      W_RD_STS: begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFF_STAT);  end
      W_RD_BUF: begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFF_BUF);   end
      W_RD_NXT: begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFF_NEXT);  end
      W_RD_DAT: begin mem_req = 1'b1; mem_addr = {ba_q[AW-1:2], 2'b00};  end
      W_WB:     begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_q + AW'(OFF_STAT); end
      default: ;
    endcase
  end

  assign mem_wdata  = sts_q | (WORD_W'(1) << DONE_BIT);
  assign ser_load   = (st_q == W_WT_DAT) && mem_rvalid;
  assign ser_word   = mem_rdata;
  assign ser_lane   = ba_q[1:0];
  assign ser_cnt    = take;
  assign ser_last   = eop_q && (rem_q == take_w);
  assign poll_start = (st_q == W_WT_STS) && mem_rvalid && (hold_q || mem_rdata[DONE_BIT]);
  assign idle       = (st_q == W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= W_IDLE;
      cur_q  <= '0;
      nxt_q  <= '0;
      ba_q   <= '0;
      rem_q  <= '0;
      hold_q <= 1'b0;
      eop_q  <= 1'b0;
      sts_q  <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (start) begin
          cur_q <= base & DESC_MASK;
          st_q  <= W_RD_PAR;
        end
        W_RD_PAR: st_q <= W_WT_PAR;
        W_WT_PAR: if (mem_rvalid) begin
          hold_q <= mem_rdata[HOLD_BIT];
          eop_q  <= mem_rdata[EOP_BIT];
          rem_q  <= mem_rdata[CNT_W-1:0];
          st_q   <= W_RD_STS;
        end
        W_RD_STS: st_q <= W_WT_STS;
        W_WT_STS: if (mem_rvalid) begin
          sts_q <= mem_rdata;
          st_q  <= (hold_q || mem_rdata[DONE_BIT]) ? W_PARK : W_RD_BUF;
        end
        W_RD_BUF: st_q <= W_WT_BUF;
        W_WT_BUF: if (mem_rvalid) begin
          ba_q <= mem_rdata[AW-1:0];
          st_q <= W_RD_NXT;
        end
        W_RD_NXT: st_q <= W_WT_NXT;
        W_WT_NXT: if (mem_rvalid) begin
          nxt_q <= mem_rdata[AW-1:0] & DESC_MASK;
          st_q  <= (rem_q == '0) ? W_WB : W_RD_DAT;
        end
        W_RD_DAT: st_q <= W_WT_DAT;
        W_WT_DAT: if (mem_rvalid) begin
          ba_q  <= ba_q + AW'(take);
          rem_q <= rem_q - take_w;
          st_q  <= W_EMIT;
        end
        W_EMIT: if (ser_idle) st_q <= (rem_q == '0) ? W_WB : W_RD_DAT;
        W_WB: begin
          if (run) begin
            cur_q <= nxt_q;
            st_q  <= W_RD_PAR;
          end else begin
            st_q  <= W_IDLE;
          end
        end
        W_PARK: begin
          if (!run)                 st_q <= W_IDLE;
          else if (kick || poll_exp) st_q <= W_RD_PAR;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00); // R13
  AST_HELD_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    st_q == W_RD_DAT |-> !hold_q && !sts_q[DONE_BIT]); // R3
  AST_WB_STATUS_WORD: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req && mem_wdata[DONE_BIT] && mem_addr[3:0] == 4'(OFF_STAT)); // R9
  AST_READ_EXPECTED: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> st_q inside {W_WT_PAR, W_WT_STS, W_WT_BUF, W_WT_NXT, W_WT_DAT}); // R2
  AST_PARK_SER_IDLE: assert property (@(posedge clk) disable iff (rst)
    st_q == W_PARK |-> ser_idle); // R3
endmodule

// File: rtl/txr_dma_top.sv
module txr_dma_top import txr_pkg::*; #(
  parameter int AW = 32,
  parameter int PW = 8,
  parameter int POLL_RESET = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  input  logic [AW-1:0] base_addr,
  input  logic [PW-1:0] poll_ivl,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready
);
  logic              run, start, kick, w_idle, poll_start, poll_exp;
  logic [AW-1:0]     base_q;
  logic [PW-1:0]     poll_q;
  logic              ser_load, ser_last, ser_idle;
  logic [WORD_W-1:0] ser_word;
  logic [1:0]        ser_lane;
  logic [2:0]        ser_cnt;

  txr_cmd #(.AW(AW), .PW(PW), .POLL_RESET(POLL_RESET)) u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .base_addr(base_addr), .poll_ivl(poll_ivl), .walker_idle(w_idle),
    .run_q(run), .start_q(start), .kick_q(kick), .base_q(base_q), .poll_q(poll_q)
  );

  txr_poll_timer #(.PW(PW)) u_poll (
    .clk(clk), .rst(rst), .start(poll_start), .ivl(poll_q), .expired(poll_exp)
  );

  txr_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst(rst), .start(start), .base(base_q), .run(run), .kick(kick),
    .poll_exp(poll_exp), .poll_start(poll_start), .idle(w_idle),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ser_load(ser_load), .ser_word(ser_word), .ser_lane(ser_lane), .ser_cnt(ser_cnt),
    .ser_last(ser_last), .ser_idle(ser_idle)
  );

  txr_byte_out #(.DW(WORD_W)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .load_word(ser_word), .load_lane(ser_lane),
    .load_cnt(ser_cnt), .load_last(ser_last), .idle(ser_idle),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  AST_LAST_FINAL: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> u_walk.rem_q == '0 && u_walk.eop_q); // R7
endmodule

// File: tb/txr_dma_top_tb.sv
module txr_dma_top_tb;
  localparam int AW = 32;
  localparam int PW = 8;
  localparam logic [31:0] P_HOLD = 32'h8000_0000;
  localparam logic [31:0] P_EOP  = 32'h4000_0000;
  localparam logic [31:0] P_SOP  = 32'h2000_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          cmd_valid;
  logic [1:0]    cmd_code;
  logic [AW-1:0] base_addr;
  logic [PW-1:0] poll_ivl;
  logic          mem_req, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          out_valid, out_last, out_ready;
  logic [7:0]    out_data;

  txr_dma_top #(.AW(AW), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .base_addr(base_addr), .poll_ivl(poll_ivl),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  int n_chk = 0;
  int n_err = 0;
  bit fin = 0;

  function automatic logic [7:0] pat(input int a);
    pat = 8'(a) ^ 8'h5A;
  endfunction

  // memory model: 256 words, two-cycle read latency
  logic        h_we;
  logic [31:0] h_addr, h_data;
  logic [31:0] mem [0:255];
  logic        p_v;
  logic [7:0]  p_i;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++)
        mem[i] <= {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
      p_v        <= 1'b0;
      p_i        <= '0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      if (h_we) mem[h_addr[9:2]] <= h_data;
      if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      p_v        <= mem_req && !mem_we;
      p_i        <= mem_addr[9:2];
      mem_rvalid <= p_v;
      mem_rdata  <= mem[p_i];
    end
  end

  // monitor and ready generator, away from the active edge
  logic [15:0] lfsr = 16'hACE1;
  bit          ready_mode;
  logic [7:0]  cap_d [0:255];
  bit          cap_l [0:255];
  int          cap_n, total_req, stall_err;
  int          desc_rd [0:63];
  bit          prev_stall, prev_last;
  logic [7:0]  prev_data;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = ready_mode ? lfsr[1] : 1'b1;
    if (rst) begin
      cap_n = 0; total_req = 0; stall_err = 0; prev_stall = 0;
      for (int i = 0; i < 64; i++) desc_rd[i] = 0;
    end else begin
      if (prev_stall && (!out_valid || out_data != prev_data || out_last != prev_last))
        stall_err++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      if (out_valid && out_ready) begin
        cap_d[cap_n] = out_data;
        cap_l[cap_n] = out_last;
        cap_n++;
      end
      if (mem_req) total_req++;
      if (mem_req && !mem_we && mem_addr[3:0] == 4'h0) desc_rd[mem_addr[9:4]]++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a; h_data = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] par, input logic [31:0] nxt,
                          input logic [31:0] ptr, input logic [31:0] sts);
    poke(a, par); poke(a + 4, nxt); poke(a + 8, ptr); poke(a + 12, sts);
  endtask

  task automatic send_cmd(input logic [1:0] code, input logic [31:0] base, input logic [7:0] ivl);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = code; base_addr = base; poll_ivl = ivl;
    @(negedge clk); cmd_valid = 1'b0; cmd_code = 2'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input logic [31:0] a, input string tag);
    for (int i = 0; i < 3000; i++) begin
      if (mem[(a + 12) >> 2][31]) break;
      @(negedge clk);
    end
    chk(mem[(a + 12) >> 2][31], tag, mem[(a + 12) >> 2], 32'h8000_0000);
  endtask

  task automatic check_seg(input int start, input int dptr, input int len, input bit eop, input string tag);
    for (int k = 0; k < len; k++) begin
      chk(cap_d[start + k] == pat(dptr + k), {tag, " data"}, 32'(cap_d[start + k]), 32'(pat(dptr + k)));
      chk(cap_l[start + k] == (eop && k == len - 1), {tag, " last"}, 32'(cap_l[start + k]),
          32'(eop && k == len - 1));
    end
  endtask

  task automatic t_reset;
    idle(2);
    chk(!out_valid, "R1 stream idle after reset", 32'(out_valid), 0);
    chk(!mem_req, "R1 no request after reset", 32'(mem_req), 0);
  endtask

  task automatic t_early_cmds;
    send_cmd(2'd2, 32'h100, 8'd7);
    send_cmd(2'd3, 32'h100, 8'd7);
    idle(20);
    chk(total_req == 0, "R1 commands before init", 32'(total_req), 0);
  endtask

  task automatic t_basic;
    put_desc(32'h100, P_SOP | P_EOP | 32'd5, 32'h110, 32'h200, 32'h0000_1234);
    put_desc(32'h110, P_SOP | 32'd6, 32'h12A, 32'h213, 32'h0);
    put_desc(32'h120, P_HOLD | P_EOP | 32'd3, 32'h10F, 32'h240, 32'h0);
    send_cmd(2'd1, 32'h107, 8'd100);
    wait_done(32'h110, "R9 second descriptor completes");
    idle(10);
    chk(desc_rd[16] == 1, "R2 base low bits ignored", 32'(desc_rd[16]), 1);
    chk(mem[32'h10C >> 2] == 32'h8000_1234, "R9 status bits kept", mem[32'h10C >> 2], 32'h8000_1234);
    chk(cap_n == 11, "R6 byte count", 32'(cap_n), 11);
    check_seg(0, 32'h200, 5, 1'b1, "R7 aligned eop");
    check_seg(5, 32'h213, 6, 1'b0, "R6 unaligned no eop");
    chk(desc_rd[18] == 1, "R10 next pointer low bits ignored", 32'(desc_rd[18]), 1);
    chk(!mem[32'h12C >> 2][31], "R3 held not completed", mem[32'h12C >> 2], 0);
    begin
      int r = desc_rd[18];
      idle(40);
      chk(desc_rd[18] == r, "R4 no re-read inside poll window", 32'(desc_rd[18]), 32'(r));
      chk(cap_n == 11, "R3 held emits nothing", 32'(cap_n), 11);
    end
  endtask

  task automatic t_hold_release;
    int s0, r, w;
    poke(32'h120, P_EOP | 32'd3);
    s0 = cap_n; r = desc_rd[18]; w = desc_rd[16];
    send_cmd(2'd2, 32'h0, 8'd0);
    idle(6);
    chk(desc_rd[18] > r, "R5 release re-reads at once", 32'(desc_rd[18]), 32'(r + 1));
    wait_done(32'h120, "R5 released descriptor completes");
    idle(10);
    check_seg(s0, 32'h240, 3, 1'b1, "R7 released packet");
    chk(desc_rd[16] > w, "R10 ring wraps to first", 32'(desc_rd[16]), 32'(w + 1));
    chk(cap_n == s0 + 3, "R3 completed entry not resent", 32'(cap_n), 32'(s0 + 3));
  endtask

  task automatic t_poll_zero;
    int s0 = cap_n;
    poke(32'h100, P_EOP);
    poke(32'h10C, 32'h0);
    wait_done(32'h100, "R4 poll picks up released entry");
    idle(10);
    chk(cap_n == s0, "R11 zero count emits nothing", 32'(cap_n), 32'(s0));
    chk(mem[32'h10C >> 2] == 32'h8000_0000, "R11 zero count completed", mem[32'h10C >> 2], 32'h8000_0000);
  endtask

  task automatic t_backpressure;
    int s0 = cap_n;
    ready_mode = 1'b1;
    poke(32'h110, P_EOP | 32'd9);
    poke(32'h118, 32'h281);
    poke(32'h11C, 32'h0);
    send_cmd(2'd2, 32'h0, 8'd0);
    wait_done(32'h110, "R8 stalled descriptor completes");
    idle(5);
    check_seg(s0, 32'h281, 9, 1'b1, "R8 stalled stream");
    chk(stall_err == 0, "R8 byte held while not ready", 32'(stall_err), 0);
    chk(cap_n == s0 + 9, "R6 count under stalls", 32'(cap_n), 32'(s0 + 9));
    ready_mode = 1'b0;
  endtask

  task automatic t_off_restart;
    int t0, s0;
    send_cmd(2'd3, 32'h0, 8'd0);
    idle(10);
    t0 = total_req;
    poke(32'h120, P_EOP | 32'd2);
    poke(32'h128, 32'h2F0);
    poke(32'h12C, 32'h0);
    send_cmd(2'd2, 32'h0, 8'd0);
    idle(150);
    chk(total_req == t0, "R12 stopped channel quiet", 32'(total_req), 32'(t0));
    chk(!mem[32'h12C >> 2][31], "R12 nothing completed while off", mem[32'h12C >> 2], 0);
    s0 = cap_n;
    send_cmd(2'd1, 32'h120, 8'd7);
    wait_done(32'h120, "R12 restart completes");
    idle(5);
    check_seg(s0, 32'h2F0, 2, 1'b1, "R12 restart data");
    chk(cap_n == s0 + 2, "R12 restart count", 32'(cap_n), 32'(s0 + 2));
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_code = 2'd0; base_addr = '0; poll_ivl = '0;
    h_we = 1'b0; h_addr = '0; h_data = '0; ready_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_early_cmds;
    t_basic;
    t_hold_release;
    t_poll_zero;
    t_backpressure;
    t_off_restart;
    if (!fin) begin
      fin = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule